// File: doc/BRIEF.md
# Dataflow GCD Sort-Difference Datapath

This block finds the greatest common divisor of two nonzero unsigned operands. It is built as a single-rate dataflow loop. Two token registers feed a combinational sort actor, which places the larger value on one output and the smaller on the other. A combinational difference actor follows it, and its outputs are written back into the token registers. Every clock fires both actors once, so each cycle performs one full subtract step of the algorithm. No sequencing state machine is involved.

A pulse on `start_i` loads `a_i` and `b_i` into the two token registers and overrides the feedback for that cycle. The loop then runs without further control. When the two tokens become equal, that value is the divisor. `done_o` rises, and the loop holds until the next load. The number of cycles needed depends on the operands: with the default 8-bit width it is at most 255.

Top module: `gcd_dataflow`

## Requirements
- R1: While `rst_ni` is low, and after its release with no load, both tokens are zero: `result_o` is 0 and `done_o` is 1.
- R2: A cycle with `start_i` high makes `result_o` equal to that cycle's `a_i` after the next rising edge. Token B is loaded with `b_i` at the same edge.
- R3: A load while a computation is still running discards that computation. The following cycles depend only on the new operands.
- R4: On each clock with `start_i` low and the tokens unequal, the new token A is max−min and the new token B is min. Both are taken from the current token values.
- R5: `done_o` is 1 exactly when the two tokens are equal. While `done_o` is 1 and `start_i` is low, `result_o` and `done_o` do not change.
- R6: After a load of nonzero operands a and b, `done_o` eventually rises with `result_o` equal to gcd(a, b). The tokens never become zero on the way.
- R7: The result does not depend on operand order: loading (b, a) yields the same divisor as (a, b).
- R8: Loading equal operands gives `done_o` = 1 with `result_o` = a on the first cycle after the load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock that fires the whole loop |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load operands into the token registers |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| done_o | output | 1 | Tokens equal, result valid |
| result_o | output | WIDTH | Current token A; the divisor when done_o is 1 |

## Verification
The checker assumes that every operand presented with `start_i` is nonzero. Under that assumption, the sum of the two tokens strictly falls on each running step, and neither token reaches zero. The stimulus keeps to this assumption by drawing operands from 1 to the maximum value. It also includes the equal-operand, unit-operand and swapped-order cases, as well as a restart issued mid-run. A behavioural model in the bench advances alongside the block every clock.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
  localparam int unsigned DEFAULT_WIDTH = 8;
  localparam int unsigned NUM_TOKENS    = 2;
  typedef enum logic {TOK_A = 1'b0, TOK_B = 1'b1} tok_idx_e;
endpackage

// File: rtl/gcd_sort_actor.sv
module gcd_sort_actor #(
  parameter int unsigned WIDTH = gcd_pkg::DEFAULT_WIDTH
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  output logic [WIDTH-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o
);
  logic x_gt;
  assign x_gt = x_i > y_i;
  assign hi_o = x_gt ? x_i : y_i;
  assign lo_o = x_gt ? y_i : x_i;
endmodule

// File: rtl/gcd_diff_actor.sv
module gcd_diff_actor #(
  parameter int unsigned WIDTH = gcd_pkg::DEFAULT_WIDTH
) (
  input  logic [WIDTH-1:0] hi_i,
  input  logic [WIDTH-1:0] lo_i,
  output logic [WIDTH-1:0] first_o,
  output logic [WIDTH-1:0] second_o
);
  // equal inputs pass through, giving a fixed point
  assign first_o  = (hi_i != lo_i) ? hi_i - lo_i : hi_i;
  assign second_o = lo_i;
endmodule

// File: rtl/gcd_token_reg.sv
module gcd_token_reg #(
  parameter int unsigned WIDTH = gcd_pkg::DEFAULT_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] seed_i,
  input  logic [WIDTH-1:0] next_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= seed_i;
    else             q_o <= next_i;
  end
endmodule

// File: rtl/gcd_dataflow.sv
module gcd_dataflow #(
  parameter int unsigned WIDTH = gcd_pkg::DEFAULT_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o
);
  import gcd_pkg::*;

  logic [NUM_TOKENS-1:0][WIDTH-1:0] tok_q, tok_next, tok_seed;
  logic [WIDTH-1:0] sort_hi, sort_lo;
  logic [WIDTH-1:0] tok_a, tok_b;

  assign tok_seed[TOK_A] = a_i;
  assign tok_seed[TOK_B] = b_i;

  gcd_sort_actor #(.WIDTH(WIDTH)) u_sort (
    .x_i (tok_q[TOK_A]),
    .y_i (tok_q[TOK_B]),
    .hi_o(sort_hi),
    .lo_o(sort_lo)
  );

  gcd_diff_actor #(.WIDTH(WIDTH)) u_diff (
    .hi_i    (sort_hi),
    .lo_i    (sort_lo),
    .first_o (tok_next[TOK_A]),
    .second_o(tok_next[TOK_B])
  );

  for (genvar t = 0; t < NUM_TOKENS; t++) begin : g_tok
    gcd_token_reg #(.WIDTH(WIDTH)) u_reg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(start_i),
      .seed_i(tok_seed[t]),
      .next_i(tok_next[t]),
      .q_o   (tok_q[t])
    );
  end

  assign tok_a    = tok_q[TOK_A];
  assign tok_b    = tok_q[TOK_B];
  assign done_o   = tok_a == tok_b;
  assign result_o = tok_a;
endmodule

// File: rtl/gcd_dataflow_chk.sv
module gcd_dataflow_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             done_o,
  input logic [WIDTH-1:0] result_o,
  input logic [WIDTH-1:0] tok_a,
  input logic [WIDTH-1:0] tok_b
);
  logic [WIDTH:0] tok_sum;
  assign tok_sum = {1'b0, tok_a} + {1'b0, tok_b};

  // input assumption: operands nonzero
  assert_nonzero_operands_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (a_i != '0) && (b_i != '0));

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (result_o == $past(a_i)) && (tok_b == $past(b_i)));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o && $stable(result_o));

  assert_progress_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && !start_i) |=> tok_sum < $past(tok_sum));

  assert_tokens_live_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && !start_i) |=> (tok_a != '0) && (tok_b != '0));
endmodule

bind gcd_dataflow gcd_dataflow_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .done_o  (done_o),
  .result_o(result_o),
  .tok_a   (tok_a),
  .tok_b   (tok_b)
);

// File: tb/tb_gcd_dataflow.sv
`timescale 1ns/1ps
module tb_gcd_dataflow;
  localparam int W = 8;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic done;
  logic [W-1:0] result;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R4";
  int ma = 0, mb = 0;

  always #5 clk = ~clk;

  gcd_dataflow #(.WIDTH(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .a_i(a), .b_i(b), .done_o(done), .result_o(result)
  );

  function automatic int gcd_sw(input int x, input int y);
    int t;
    while (y != 0) begin t = x % y; x = y; y = t; end
    return x;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin ma = 0; mb = 0; end
    else if (start) begin ma = int'(a); mb = int'(b); end
    else if (ma != mb) begin
      int hi, lo;
      hi = (ma > mb) ? ma : mb;
      lo = (ma > mb) ? mb : ma;
      ma = hi - lo; mb = lo;
    end
  end

  always @(negedge clk) begin
    check({cur_req, " result"}, int'(result), ma);
    check({cur_req, " done"}, int'(done), int'(ma == mb));
  end

  task automatic load(input int x, input int y);
    @(negedge clk);
    start = 1'b1; a = W'(x); b = W'(y);
    @(negedge clk);
    start = 1'b0;
    check("R2 load", int'(result), x);
  endtask

  task automatic wait_done(input string req, input int x, input int y);
    int k = 0;
    while (!done && k < MAXV + 4) begin @(negedge clk); k++; end
    check({req, " gcd"}, int'(result), gcd_sw(x, y));
    check({req, " done"}, int'(done), 1);
  endtask

  task automatic run_pair(input string req, input int x, input int y);
    load(x, y);
    wait_done(req, x, y);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R5 hold", int'(result), gcd_sw(x, y));
    end
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("R1 reset result", int'(result), 0);
    check("R1 reset done", int'(done), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle result", int'(result), 0);
    check("R1 idle done", int'(done), 1);

    cur_req = "R4";
    run_pair("R6", 12, 18);
    run_pair("R7", 18, 12);
    run_pair("R6 coprime", 255, 254);
    run_pair("R6 unit", 255, 1);
    run_pair("R7 unit", 1, 200);

    cur_req = "R8";
    load(77, 77);
    check("R8 equal done", int'(done), 1);
    check("R8 equal result", int'(result), 77);
    cur_req = "R4";

    // restart mid-run
    cur_req = "R3";
    load(250, 3);
    repeat (4) @(negedge clk);
    check("R3 busy", int'(done), 0);
    run_pair("R3", 48, 36);
    cur_req = "R4";

    for (int i = 0; i < 40; i++) begin
      int x, y;
      x = $urandom_range(1, MAXV);
      y = $urandom_range(1, MAXV);
      run_pair("R6 rand", x, y);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule